// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Control

This block is the data-hazard controller of a five-stage in-order integer pipeline. Each cycle it takes the two source register numbers held in the decode-to-execute register. It compares them with the destination numbers held further down the pipe, in the execute-to-memory register and the memory-to-writeback register. From those comparisons it picks, for each ALU operand, whether the value comes from the register file, the writeback stage result, or the memory stage result.

The same unit also catches the one dependency that forwarding cannot cover: a load whose data is needed by the very next instruction. The dependent instruction is still in decode when the load sits in execute. When this happens, the unit holds the program counter and the fetch-to-decode register for one cycle and turns the instruction entering execute into a bubble. All logic is combinational, so every output follows its inputs within the same cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select is a 2-bit code. 2'b00 selects the register file, 2'b01 selects the writeback-stage result, and 2'b10 selects the memory-stage result. The code 2'b11 never appears, and both selects are 2'b00 when no stage matches.
- R2: Operand A select is 2'b10 when the memory stage writes a register, its destination is non-zero, and that destination equals the execute-stage first source. This also holds for register 31.
- R3: Operand B select is 2'b10 when the memory stage writes a register, its destination is non-zero, and that destination equals the execute-stage second source.
- R4: An operand select is 2'b01 when the writeback stage writes a register, its destination is non-zero, it equals that operand's source, and the memory stage does not forward to that operand.
- R5: When both stages qualify for the same operand, the memory-stage result (2'b10) is chosen.
- R6: Register 0 is never forwarded, even when a stage with destination 0 has its write flag set.
- R7: A stage whose write flag is clear never causes forwarding, whatever its destination number. A stage further back may still forward in that case.
- R8: A load-use stall occurs when the execute-stage read-memory flag is set, the execute-stage second source (the load destination) is non-zero, and it equals either source of the decode-stage instruction. During a stall, pc_wr_en and if_id_wr_en are 0 and ex_bubble is 1.
- R9: Without a stall condition, pc_wr_en and if_id_wr_en are 1 and ex_bubble is 0.
- R10: A load whose destination is register 0 never causes a stall.
- R11: Forwarding and stall outputs are independent. Both take effect in the same cycle in which their inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number in the execute stage |
| ex_src_b | input | 5 | Second source register number in the execute stage (load destination for loads) |
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| mem_dst | input | 5 | Destination register number in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register number in the writeback stage |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| dec_src_a | input | 5 | First source register number in the decode stage |
| dec_src_b | input | 5 | Second source register number in the decode stage |
| fwd_a_sel | output | 2 | Operand A multiplexer select |
| fwd_b_sel | output | 2 | Operand B multiplexer select |
| pc_wr_en | output | 1 | Program counter update enable |
| if_id_wr_en | output | 1 | Fetch-to-decode register update enable |
| ex_bubble | output | 1 | Clear control of the instruction entering execute |

## Verification
The embedded assertions are checked on every evaluation. They cover the select code range, the rule that a memory-stage or writeback-stage select appears only when that stage is writing a non-zero register, and the lock-step of the three stall outputs. Some behaviours only the bench scenarios can show. These are the exact choice between competing stages, the boundary register numbers 0 and 31, a non-writing stage letting an older one forward, and a stall that coincides with active forwarding.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic             wr;
    } stage_wr_t;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import hzd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mem_dst,
    input  logic         mem_wr,
    input  logic [W-1:0] wb_dst,
    input  logic         wb_wr,
    output fwd_sel_e     sel
);
    logic mem_hit_d;
    logic wb_hit_d;

    always_comb begin
        mem_hit_d = mem_wr && (mem_dst != '0) && (mem_dst == src);
        wb_hit_d  = wb_wr  && (wb_dst  != '0) && (wb_dst  == src);
        if (mem_hit_d)
            sel = SEL_MEM;
        else if (wb_hit_d)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

    // Assertions relate the select to the raw stage inputs.
    always_comb begin
        assert_sel_code_R1: assert (sel != fwd_sel_e'(2'b11));
        if (sel == SEL_MEM) begin
            assert_mem_qualified_R2: assert (mem_wr && mem_dst != '0 && mem_dst == src);
        end
        if (sel == SEL_WB) begin
            assert_wb_qualified_R4: assert (wb_wr && wb_dst != '0 && wb_dst == src);
            assert_mem_priority_R5: assert (!(mem_wr && mem_dst != '0 && mem_dst == src));
        end
        if (src == '0) begin
            assert_zero_never_fwd_R6: assert (sel == SEL_RF);
        end
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import hzd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         ex_is_load,
    input  logic [W-1:0] ex_load_dst,
    input  logic [W-1:0] dec_src_a,
    input  logic [W-1:0] dec_src_b,
    output logic         stall
);
    logic dep_d;

    always_comb begin
        dep_d = (ex_load_dst == dec_src_a) || (ex_load_dst == dec_src_b);
        stall = ex_is_load && (ex_load_dst != '0) && dep_d;
    end

    always_comb begin
        if (!ex_is_load) begin
            assert_no_load_no_stall_R9: assert (!stall);
        end
        if (ex_load_dst == '0) begin
            assert_zero_dst_no_stall_R10: assert (!stall);
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] ex_src_a,
    input  logic [W-1:0] ex_src_b,
    input  logic         ex_is_load,
    input  logic [W-1:0] mem_dst,
    input  logic         mem_wr,
    input  logic [W-1:0] wb_dst,
    input  logic         wb_wr,
    input  logic [W-1:0] dec_src_a,
    input  logic [W-1:0] dec_src_b,
    output logic [1:0]   fwd_a_sel,
    output logic [1:0]   fwd_b_sel,
    output logic         pc_wr_en,
    output logic         if_id_wr_en,
    output logic         ex_bubble
);
    localparam int NSRC = NUM_SRC;

    logic [NSRC-1:0][W-1:0] src_vec;
    fwd_sel_e               sel_vec [NSRC];
    logic                   stall_d;

    assign src_vec[0] = ex_src_a;
    assign src_vec[1] = ex_src_b;

    for (genvar g = 0; g < NSRC; g++) begin : g_operand
        fwd_operand_sel #(.W(W)) u_sel (
            .src     (src_vec[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (sel_vec[g])
        );
    end

    load_use_detect #(.W(W)) u_lu (
        .ex_is_load  (ex_is_load),
        .ex_load_dst (ex_src_b),
        .dec_src_a   (dec_src_a),
        .dec_src_b   (dec_src_b),
        .stall       (stall_d)
    );

    always_comb begin
        fwd_a_sel   = sel_vec[0];
        fwd_b_sel   = sel_vec[1];
        pc_wr_en    = !stall_d;
        if_id_wr_en = !stall_d;
        ex_bubble   = stall_d;
    end

    always_comb begin
        assert_hold_lockstep_R8: assert (pc_wr_en == if_id_wr_en);
        assert_bubble_vs_hold_R8: assert (ex_bubble != pc_wr_en);
        if (!mem_wr && !wb_wr) begin
            assert_no_writer_no_fwd_R7: assert (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00);
        end
    end
endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [4:0] ex_src_a, ex_src_b, mem_dst, wb_dst, dec_src_a, dec_src_b;
    logic       ex_is_load, mem_wr, wb_wr;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       pc_wr_en, if_id_wr_en, ex_bubble;

    pipe_hazard_ctrl dut_i (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_wr_en(pc_wr_en), .if_id_wr_en(if_id_wr_en), .ex_bubble(ex_bubble)
    );

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       stall;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb, input logic ld,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww,
                         input logic [4:0] da, input logic [4:0] db,
                         input logic [1:0] ea, input logic [1:0] eb,
                         input logic es, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        ex_src_a = sa; ex_src_b = sb; ex_is_load = ld;
        mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
        dec_src_a = da; dec_src_b = db;
        e.a = ea; e.b = eb; e.stall = es; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: outputs are combinational, so sample at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (fwd_a_sel !== e.a || fwd_b_sel !== e.b || ex_bubble !== e.stall ||
                    pc_wr_en !== !e.stall || if_id_wr_en !== !e.stall) begin
                    n_fail++;
                    $display("FAIL %s: got a=%b b=%b pc=%b ifid=%b bub=%b, expected a=%b b=%b stall=%b",
                             e.tag, fwd_a_sel, fwd_b_sel, pc_wr_en, if_id_wr_en, ex_bubble,
                             e.a, e.b, e.stall);
                end
            end
        end
    end

    initial begin
        ex_src_a = 0; ex_src_b = 0; ex_is_load = 0; mem_dst = 0; mem_wr = 0;
        wb_dst = 0; wb_wr = 0; dec_src_a = 0; dec_src_b = 0;
        // R1 idle state: nothing matches
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R1 idle");
        drive(3, 4, 0, 9, 1, 10, 1, 0, 0, 2'b00, 2'b00, 0, "R1 no match");
        // R2 / R3 memory-stage forwarding
        drive(3, 4, 0, 3, 1, 0, 0, 0, 0, 2'b10, 2'b00, 0, "R2 mem to A");
        drive(31, 4, 0, 31, 1, 0, 0, 0, 0, 2'b10, 2'b00, 0, "R2 reg31");
        drive(3, 4, 0, 4, 1, 0, 0, 0, 0, 2'b00, 2'b10, 0, "R3 mem to B");
        // R4 writeback-stage forwarding
        drive(5, 6, 0, 0, 0, 5, 1, 0, 0, 2'b01, 2'b00, 0, "R4 wb to A");
        drive(5, 6, 0, 0, 0, 6, 1, 0, 0, 2'b00, 2'b01, 0, "R4 wb to B");
        drive(5, 6, 0, 6, 1, 5, 1, 0, 0, 2'b01, 2'b10, 0, "R4 mixed stages");
        // R5 priority
        drive(7, 7, 0, 7, 1, 7, 1, 0, 0, 2'b10, 2'b10, 0, "R5 both stages");
        // R6 register 0
        drive(0, 0, 0, 0, 1, 0, 1, 0, 0, 2'b00, 2'b00, 0, "R6 zero reg");
        // R7 write flag clear
        drive(9, 9, 0, 9, 0, 9, 0, 0, 0, 2'b00, 2'b00, 0, "R7 no writers");
        drive(9, 2, 0, 9, 0, 9, 1, 0, 0, 2'b01, 2'b00, 0, "R7 wb passes");
        // R8 load-use stall
        drive(0, 8, 1, 0, 0, 0, 0, 8, 1, 2'b00, 2'b00, 1, "R8 dep on src a");
        drive(0, 8, 1, 0, 0, 0, 0, 1, 8, 2'b00, 2'b00, 1, "R8 dep on src b");
        // R9 no stall
        drive(0, 8, 1, 0, 0, 0, 0, 2, 3, 2'b00, 2'b00, 0, "R9 load no dep");
        drive(0, 8, 0, 0, 0, 0, 0, 8, 8, 2'b00, 2'b00, 0, "R9 not a load");
        // R10 load to register 0
        drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R10 zero dst");
        // R11 stall and forwarding together
        drive(8, 8, 1, 8, 1, 0, 0, 8, 0, 2'b10, 2'b10, 1, "R11 fwd plus stall");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, "R11 release");
        wait (exp_q.size() == 0);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule